// File: doc/BRIEF.md
# Subcode Q Serial Readout Port

This block holds one 80-bit subcode Q word and its status for a host microcontroller. A frame strobe offers a new word, a CRC-pass bit, the 4-bit address field and an address-free mode bit. When the status qualifies, a ready flag rises. The host then clocks the word out one bit at a time, least significant bit first, on its own slow clock.

The first host clock edge freezes the register, so a frame arriving mid-read cannot corrupt it. A brief pulse on the release strobe ends the read, clears the ready flag and lets new frames in again. If the host never starts reading, the ready flag lapses after a timeout counted in ticks of an external timebase; the default is 112 ticks of 0.1 ms.

The host clock and the release strobe are asynchronous. Both pass through a synchronizer and an edge detector before use. An active-low select gates the port, and its serial output has an enable for a high-impedance driver.

Top module: `subq_readout`

## Requirements
- R1: An accepted frame raises `ready_o` in the cycle after the strobe only if `crc_ok_i` is 1 and `addr_field_i` equals 4'd1; otherwise `ready_o` is 0 after that frame.
- R2: With `addr_free_i` at 1, the address field is ignored and `crc_ok_i` alone decides `ready_o`.
- R3: With `ready_o` high and no read started, `ready_o` falls on the TIMEOUT_TICKS-th `tick_i` pulse after the accepted frame (default 112). Once a read has started, ticks do not lower it.
- R4: `q_bit_o` presents bit 0 of the captured word. Each rising host clock edge while selected advances it to the next higher bit. After FRAME_W edges it reads 0.
- R5: The first selected host clock edge freezes the register. Frames offered while frozen are discarded and change neither the word nor `ready_o`.
- R6: A rising edge on `host_rel_i` unfreezes the register and forces `ready_o` low. Later frames are accepted again.
- R7: With `sel_ni` high, `q_oe_o` and `q_bit_o` are 0, and host clock edges neither shift nor freeze the register.
- R8: Host inputs pass two synchronizer flops and an edge detector. A rising `host_rel_i` takes effect on the third system clock edge after it changes, not the second.
- R9: Every accepted frame restarts the expiry count from zero.
- R10: After reset `ready_o` is 0, the register is unfrozen, and the word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_load_i | input | 1 | Strobe offering a new Q word |
| frame_data_i | input | FRAME_W | Q word, bit 0 sent first |
| crc_ok_i | input | 1 | Word passed its CRC check |
| addr_field_i | input | 4 | Address mode field of the word |
| addr_free_i | input | 1 | Ignore the address field |
| tick_i | input | 1 | Timebase pulse for expiry |
| host_clk_i | input | 1 | Asynchronous host shift clock |
| host_rel_i | input | 1 | Asynchronous host release strobe |
| sel_ni | input | 1 | Active-low port select |
| q_bit_o | output | 1 | Serial data bit |
| q_oe_o | output | 1 | Output enable for the serial pad |
| ready_o | output | 1 | Word ready for reading |

## Verification
The checker watches, on every cycle, the conditions under which the ready flag may rise or fall. It also checks that a release always clears both the flag and the freeze, and that a frozen register stays frozen with its flag held until released.

Only the bench scenarios can show the order and value of the 80 shifted bits. They also show that a frame offered mid-read is discarded, that the expiry lands on exactly the right tick and restarts on a new frame, and that host clock edges are ignored while the port is deselected.

// File: rtl/subq_pkg.sv
package subq_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADDR_TARGET = 4'd1;

  typedef struct packed {
    logic              crc_ok;
    logic [ADDR_W-1:0] addr;
    logic              addr_free;
  } q_status_t;

  function automatic logic status_qualifies(input q_status_t st);
    return st.crc_ok & (st.addr_free | (st.addr == ADDR_TARGET));
  endfunction
endpackage

// File: rtl/subq_edge_sync.sv
module subq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= async_i;
  end

  // remaining sync stages plus one history flop for edge detection
  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/subq_expiry.sv
module subq_expiry #(
  parameter int unsigned TICKS = 112
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/subq_frame_reg.sv
module subq_frame_reg #(
  parameter int unsigned FRAME_W = 80
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] data_i,
  input  logic               qualify_i,
  input  logic               shift_i,
  input  logic               release_i,
  input  logic               expire_i,
  output logic               lsb_o,
  output logic               frozen_o,
  output logic               ready_o,
  output logic               accept_o
);
  logic [FRAME_W-1:0] word_q;
  logic               frozen_q;
  logic               ready_q;

  // release beats shift, shift beats load
  assign accept_o = load_i & ~frozen_q & ~shift_i & ~release_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q   <= '0;
      frozen_q <= 1'b0;
    end else if (release_i) begin
      frozen_q <= 1'b0;
    end else if (shift_i) begin
      frozen_q <= 1'b1;
      word_q   <= {1'b0, word_q[FRAME_W-1:1]};
    end else if (accept_o) begin
      word_q   <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ready_q <= 1'b0;
    else if (release_i) ready_q <= 1'b0;
    else if (accept_o)  ready_q <= qualify_i;
    else if (expire_i)  ready_q <= 1'b0;
  end

  assign lsb_o    = word_q[0];
  assign frozen_o = frozen_q;
  assign ready_o  = ready_q;
endmodule

// File: rtl/subq_readout.sv
module subq_readout
  import subq_pkg::*;
#(
  parameter int unsigned FRAME_W       = 80,
  parameter int unsigned TIMEOUT_TICKS = 112,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_load_i,
  input  logic [FRAME_W-1:0] frame_data_i,
  input  logic               crc_ok_i,
  input  logic [ADDR_W-1:0]  addr_field_i,
  input  logic               addr_free_i,
  input  logic               tick_i,
  input  logic               host_clk_i,
  input  logic               host_rel_i,
  input  logic               sel_ni,
  output logic               q_bit_o,
  output logic               q_oe_o,
  output logic               ready_o
);
  logic      clk_rise, rel_rise, shift_req;
  logic      frozen, ready, accept, expire, lsb;
  q_status_t status;

  subq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(host_clk_i), .rise_o(clk_rise)
  );

  subq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_rel (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(host_rel_i), .rise_o(rel_rise)
  );

  assign shift_req = clk_rise & ~sel_ni;

  assign status.crc_ok    = crc_ok_i;
  assign status.addr      = addr_field_i;
  assign status.addr_free = addr_free_i;

  subq_frame_reg #(.FRAME_W(FRAME_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (frame_load_i),
    .data_i    (frame_data_i),
    .qualify_i (status_qualifies(status)),
    .shift_i   (shift_req),
    .release_i (rel_rise),
    .expire_i  (expire),
    .lsb_o     (lsb),
    .frozen_o  (frozen),
    .ready_o   (ready),
    .accept_o  (accept)
  );

  subq_expiry #(.TICKS(TIMEOUT_TICKS)) u_expiry (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (accept),
    .run_i     (ready & ~frozen),
    .tick_i    (tick_i),
    .expire_o  (expire)
  );

  assign q_oe_o  = ~sel_ni;
  assign q_bit_o = ~sel_ni & lsb;
  assign ready_o = ready;
endmodule

// File: rtl/subq_readout_chk.sv
module subq_readout_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_load_i,
  input logic       crc_ok_i,
  input logic [3:0] addr_field_i,
  input logic       addr_free_i,
  input logic       tick_i,
  input logic       ready_o,
  input logic       rel_rise,
  input logic       shift_req,
  input logic       frozen
);
  assert_rise_needs_crc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(frame_load_i && crc_ok_i));

  assert_rise_needs_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(addr_free_i || addr_field_i == 4'd1));

  assert_fall_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(tick_i || rel_rise || frame_load_i));

  assert_read_holds_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && frozen && !rel_rise |=> ready_o);

  assert_shift_freezes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_req && !rel_rise |=> frozen);

  assert_freeze_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen && !rel_rise |=> frozen);

  assert_release_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_rise |=> !ready_o && !frozen);
endmodule

bind subq_readout subq_readout_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_load_i (frame_load_i),
  .crc_ok_i     (crc_ok_i),
  .addr_field_i (addr_field_i),
  .addr_free_i  (addr_free_i),
  .tick_i       (tick_i),
  .ready_o      (ready_o),
  .rel_rise     (rel_rise),
  .shift_req    (shift_req),
  .frozen       (frozen)
);

// File: tb/subq_readout_test.sv
module subq_readout_test;
  localparam int W = 80;
  localparam int TO = 112;
  localparam logic [W-1:0] FA = 80'h0123_4567_89AB_CDEF_F00D;
  localparam logic [W-1:0] FB = 80'hA5A5_5A5A_C3C3_3C3C_9669;
  localparam logic [W-1:0] FC = 80'h8000_0000_0000_0000_0006;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 1'b0, crc = 1'b0, afree = 1'b0, tick = 1'b0;
  logic [W-1:0] data = '0;
  logic [3:0] addr = '0;
  logic hclk = 1'b0, hrel = 1'b0, sel_n = 1'b1;
  logic q_bit, q_oe, ready;

  int checks = 0, fails = 0;
  logic sample_req = 1'b0;
  logic exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  subq_readout uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_load_i(load), .frame_data_i(data),
    .crc_ok_i(crc), .addr_field_i(addr), .addr_free_i(afree), .tick_i(tick),
    .host_clk_i(hclk), .host_rel_i(hrel), .sel_ni(sel_n),
    .q_bit_o(q_bit), .q_oe_o(q_oe), .ready_o(ready)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor: pops the scoreboard when the driver asks for a sample
  always @(negedge clk) begin
    if (sample_req && exp_q.size() > 0) begin
      logic e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {{(W-1){1'b0}}, q_bit}, {{(W-1){1'b0}}, e});
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic offer(input logic [W-1:0] d, input logic c, input logic [3:0] a, input logic f);
    data = d; crc = c; addr = a; afree = f; load = 1'b1;
    step(1);
    load = 1'b0;
  endtask

  task automatic hpulse();
    hclk = 1'b1; step(4);
    hclk = 1'b0; step(3);
  endtask

  task automatic read_bits(input logic [W-1:0] d, input int from, input int n, input string tag);
    for (int i = from; i < from + n; i++) begin
      exp_q.push_back(d[i]);
      tag_q.push_back(tag);
      sample_req = 1'b1; step(1);
      sample_req = 1'b0;
      hpulse();
    end
  endtask

  task automatic release_host();
    hrel = 1'b1; step(3);
    hrel = 1'b0; step(3);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(1);
      tick = 1'b0; step(1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    step(3);
    chk("R10 ready", ready, 0);
    chk("R7 oe deselected", q_oe, 0);
    rst_n = 1'b1; step(1);
    sel_n = 1'b0; step(1);
    chk("R7 oe selected", q_oe, 1);
    chk("R10 word zero", q_bit, 0);

    // full read, LSB first
    offer(FA, 1, 4'd1, 0);
    chk("R1 ready after good frame", ready, 1);
    read_bits(FA, 0, W, "R4 bit order");
    chk("R4 zero fill", q_bit, 0);
    chk("R3 ready held during read", ready, 1);
    hrel = 1'b1; step(2);
    chk("R8 release not yet seen", ready, 1);
    step(1);
    chk("R8 release on third edge", ready, 0);
    hrel = 1'b0; step(3);
    chk("R6 ready low after release", ready, 0);

    // frame offered during read is discarded
    offer(FA, 1, 4'd1, 0);
    read_bits(FA, 0, 3, "R5 before freeze");
    offer(FB, 0, 4'd1, 0);
    chk("R5 ready unchanged by frozen load", ready, 1);
    read_bits(FA, 3, W - 3, "R5 discard");
    release_host();
    chk("R6 released", ready, 0);

    // status gating
    offer(FB, 0, 4'd1, 0);
    chk("R1 crc fail", ready, 0);
    offer(FB, 1, 4'd2, 0);
    chk("R1 wrong address", ready, 0);
    offer(FB, 1, 4'd2, 1);
    chk("R2 address free", ready, 1);
    offer(FB, 1, 4'd1, 0);
    offer(FB, 0, 4'd7, 1);
    chk("R2 address free still needs crc", ready, 0);
    read_bits(FB, 0, 4, "R6 frames accepted after release");
    release_host();

    // expiry
    offer(FC, 1, 4'd1, 0);
    ticks(TO - 1);
    chk("R3 before expiry", ready, 1);
    ticks(1);
    chk("R3 expiry", ready, 0);
    offer(FC, 1, 4'd1, 0);
    ticks(100);
    offer(FC, 1, 4'd1, 0);
    ticks(100);
    chk("R9 restart on new frame", ready, 1);
    ticks(TO - 101);
    chk("R9 before restarted expiry", ready, 1);
    ticks(1);
    chk("R9 restarted expiry", ready, 0);

    // read stops expiry
    offer(FC, 1, 4'd1, 0);
    read_bits(FC, 0, 1, "R4 first bit");
    ticks(TO + 10);
    chk("R3 no expiry while reading", ready, 1);
    release_host();

    // deselected port ignores host clock
    offer(FA, 1, 4'd1, 0);
    sel_n = 1'b1; step(1);
    chk("R7 oe off", q_oe, 0);
    chk("R7 bit forced low", q_bit, 0);
    hpulse(); hpulse();
    sel_n = 1'b0; step(1);
    ticks(TO);
    chk("R7 no freeze while deselected", ready, 0);
    read_bits(FA, 0, W, "R7 no shift while deselected");
    release_host();

    step(5);
    chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule